// File: doc/BRIEF.md
# USB Host Interrupt Enable/Status Unit

This unit sits between a USB host engine and an external processor. It gathers single-cycle event pulses from the engine and turns them into one interrupt request line. The events are transfer completion on two endpoint channels, the 1 ms start-of-frame tick, device attach/detach, and a detect-or-resume event. Every event sets a bit in a pending register, whether or not that bit is enabled. The processor can poll that register and clears a bit by writing 1 to it. A separate mask register decides which pending bits drive the interrupt line.

Two bits depend on other engine state. The detect/resume bit follows the resume event while the port is suspended and the device-detect event otherwise. The frame-tick bit can only be set while the frame generator is running and its counter has been loaded. The frame counter and the detectors that produce the pulses live outside this unit.

Top module: `usbh_irq_unit`

## Requirements
- R1: After reset, `mask_q` and `pend_q` are all zero and `irq_o` is low.
- R2: A cycle with `mask_wr`=1 loads `mask_wdata` into `mask_q` at the next clock edge. Without `mask_wr`, `mask_q` holds its value.
- R3: Pending bit 0 (channel A done), bit 1 (channel B done) and bit 5 (attach/detach) are set at the clock edge that samples `ev_done_a`, `ev_done_b` or `ev_attach` high. This happens regardless of the mask.
- R4: Pending bit 4 (frame tick) is set by `ev_sof` only in a cycle where both `sof_gen_on` and `sof_cnt_loaded` are 1. Otherwise the tick is ignored.
- R5: Pending bit 6 is set by `ev_resume` while `port_suspend`=1 and by `ev_detect` while `port_suspend`=0. The event not selected in that cycle is ignored.
- R6: Bits 2 and 3 are reserved. They read 0 in both `mask_q` and `pend_q` whatever is written, and they never raise `irq_o`.
- R7: A cycle with `pend_clr_wr`=1 clears, at the next edge, each pending bit whose `pend_clr_data` bit is 1. Bits written 0 are left unchanged.
- R8: If a bit's event and its clear fall in the same cycle, the event wins and the bit stays set.
- R9: `irq_o` is high exactly when some bit is 1 in both `pend_q` and `mask_q`. It follows register changes in the same cycle and stays high until every masked pending bit is cleared or unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done_a | input | 1 | Channel A transfer-done pulse |
| ev_done_b | input | 1 | Channel B transfer-done pulse |
| ev_sof | input | 1 | 1 ms frame tick pulse |
| ev_attach | input | 1 | Device attach/detach pulse |
| ev_detect | input | 1 | Device-detect pulse |
| ev_resume | input | 1 | Resume-detect pulse |
| port_suspend | input | 1 | Port is suspended; selects the source of bit 6 |
| sof_gen_on | input | 1 | Frame generator enabled |
| sof_cnt_loaded | input | 1 | Frame counter has been loaded |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 7 | Mask write data |
| pend_clr_wr | input | 1 | Write strobe for write-1-to-clear of pending bits |
| pend_clr_data | input | 7 | Bits to clear |
| mask_q | output | 7 | Current mask register |
| pend_q | output | 7 | Current pending register |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Every pending bit and the mask are visible on ports the cycle after the edge that updates them. A wrong source choice, a missed gate on the frame tick or a clear that wins over an event therefore shows on `pend_q` one cycle after the stimulus. Because `irq_o` is a plain combination of the two visible registers, a stuck or spurious interrupt shows in the same cycle as the register state behind it. The bench compares all three outputs after every clock edge, so any divergence is caught on the first cycle it appears.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

  localparam int IRQ_W = 7;

  localparam int B_DONE_A = 0;
  localparam int B_DONE_B = 1;
  localparam int B_SOF    = 4;
  localparam int B_ATTACH = 5;
  localparam int B_DETRES = 6;

  localparam logic [IRQ_W-1:0] RSVD_MASK = 7'b000_1100;

  function automatic logic [IRQ_W-1:0] keep_used(input logic [IRQ_W-1:0] v);
    return v & ~RSVD_MASK;
  endfunction

  function automatic logic irq_any(input logic [IRQ_W-1:0] pend,
                                   input logic [IRQ_W-1:0] mask);
    return |(pend & mask);
  endfunction

endpackage

// File: rtl/usbh_irq_qual.sv
module usbh_irq_qual
  import usbh_irq_pkg::*;
(
  input  logic             ev_done_a,
  input  logic             ev_done_b,
  input  logic             ev_sof,
  input  logic             ev_attach,
  input  logic             ev_detect,
  input  logic             ev_resume,
  input  logic             port_suspend,
  input  logic             sof_gen_on,
  input  logic             sof_cnt_loaded,
  output logic [IRQ_W-1:0] set_vec
);

  logic sof_ok;
  logic detres_ev;

  assign sof_ok    = ev_sof & sof_gen_on & sof_cnt_loaded;
  assign detres_ev = port_suspend ? ev_resume : ev_detect;

  always_comb begin
    set_vec           = '0;
    set_vec[B_DONE_A] = ev_done_a;
    set_vec[B_DONE_B] = ev_done_b;
    set_vec[B_SOF]    = sof_ok;
    set_vec[B_ATTACH] = ev_attach;
    set_vec[B_DETRES] = detres_ev;
  end

endmodule

// File: rtl/usbh_irq_mask.sv
module usbh_irq_mask
  import usbh_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  mask_q <= '0;
    else if (wr) mask_q <= keep_used(wdata);
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask_q)); // R2

endmodule

// File: rtl/usbh_irq_cell.sv
module usbh_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q); // R7

endmodule

// File: rtl/usbh_irq_unit.sv
module usbh_irq_unit
  import usbh_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_done_a,
  input  logic             ev_done_b,
  input  logic             ev_sof,
  input  logic             ev_attach,
  input  logic             ev_detect,
  input  logic             ev_resume,
  input  logic             port_suspend,
  input  logic             sof_gen_on,
  input  logic             sof_cnt_loaded,
  input  logic             mask_wr,
  input  logic [IRQ_W-1:0] mask_wdata,
  input  logic             pend_clr_wr,
  input  logic [IRQ_W-1:0] pend_clr_data,
  output logic [IRQ_W-1:0] mask_q,
  output logic [IRQ_W-1:0] pend_q,
  output logic             irq_o
);

  logic [IRQ_W-1:0] set_vec;
  logic [IRQ_W-1:0] clr_vec;

  assign clr_vec = pend_clr_wr ? pend_clr_data : '0;

  usbh_irq_qual u_qual (
    .ev_done_a      (ev_done_a),
    .ev_done_b      (ev_done_b),
    .ev_sof         (ev_sof),
    .ev_attach      (ev_attach),
    .ev_detect      (ev_detect),
    .ev_resume      (ev_resume),
    .port_suspend   (port_suspend),
    .sof_gen_on     (sof_gen_on),
    .sof_cnt_loaded (sof_cnt_loaded),
    .set_vec        (set_vec)
  );

  usbh_irq_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (mask_wr),
    .wdata  (mask_wdata),
    .mask_q (mask_q)
  );

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    if (RSVD_MASK[i]) begin : g_rsvd
      assign pend_q[i] = 1'b0;
    end else begin : g_cell
      usbh_irq_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec[i]),
        .clr_i (clr_vec[i]),
        .q     (pend_q[i])
      );
    end
  end

  assign irq_o = irq_any(pend_q, mask_q);

  AST_SOF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[B_SOF]) |-> $past(ev_sof && sof_gen_on && sof_cnt_loaded)); // R4

  AST_DETRES_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[B_DETRES]) |-> $past(port_suspend ? ev_resume : ev_detect)); // R5

  AST_DONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done_a |=> pend_q[B_DONE_A]); // R3

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(pend_clr_wr || mask_wr)); // R9

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> ((mask_q & RSVD_MASK) == '0)); // R6

endmodule

// File: tb/usbh_irq_unit_tb.sv
module usbh_irq_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_done_a = 0, ev_done_b = 0, ev_sof = 0, ev_attach = 0;
  logic       ev_detect = 0, ev_resume = 0;
  logic       port_suspend = 0, sof_gen_on = 0, sof_cnt_loaded = 0;
  logic       mask_wr = 0, pend_clr_wr = 0;
  logic [6:0] mask_wdata = '0, pend_clr_data = '0;
  logic [6:0] mask_q, pend_q;
  logic       irq_o;

  always #4 clk = ~clk;

  usbh_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_done_a(ev_done_a), .ev_done_b(ev_done_b), .ev_sof(ev_sof),
    .ev_attach(ev_attach), .ev_detect(ev_detect), .ev_resume(ev_resume),
    .port_suspend(port_suspend), .sof_gen_on(sof_gen_on),
    .sof_cnt_loaded(sof_cnt_loaded),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .pend_clr_wr(pend_clr_wr), .pend_clr_data(pend_clr_data),
    .mask_q(mask_q), .pend_q(pend_q), .irq_o(irq_o)
  );

  typedef struct {
    logic [6:0] pend;
    logic [6:0] mask;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q_exp[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   finished = 0;
  logic [6:0] m_pend = '0;
  logic [6:0] m_mask = '0;

  // ev bits: 0 done_a, 1 done_b, 2 sof, 3 attach, 4 detect, 5 resume
  // cfg bits: 0 suspend, 1 sof generator on, 2 counter loaded
  task automatic step(input logic [5:0] ev, input logic [2:0] cfg,
                      input logic mw, input logic [6:0] md,
                      input logic cw, input logic [6:0] cd, input string tag);
    exp_t e;
    logic [6:0] hit;
    @(negedge clk);
    ev_done_a = ev[0]; ev_done_b = ev[1]; ev_sof = ev[2];
    ev_attach = ev[3]; ev_detect = ev[4]; ev_resume = ev[5];
    port_suspend = cfg[0]; sof_gen_on = cfg[1]; sof_cnt_loaded = cfg[2];
    mask_wr = mw; mask_wdata = md; pend_clr_wr = cw; pend_clr_data = cd;
    hit = 7'd0;
    if (ev[0]) hit[0] = 1'b1;
    if (ev[1]) hit[1] = 1'b1;
    if (ev[2] && cfg[1] && cfg[2]) hit[4] = 1'b1;
    if (ev[3]) hit[5] = 1'b1;
    if (cfg[0] ? ev[5] : ev[4]) hit[6] = 1'b1;
    if (cw) m_pend = m_pend & ~cd;
    m_pend = (m_pend | hit) & 7'b111_0011;
    if (mw) m_mask = md & 7'b111_0011;
    e.pend = m_pend; e.mask = m_mask;
    e.irq = (m_pend & m_mask) != 7'd0;
    e.tag = tag;
    q_exp.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q_exp.size() > 0) begin
      exp_t e;
      e = q_exp.pop_front();
      n_chk++;
      if (pend_q !== e.pend || mask_q !== e.mask || irq_o !== e.irq) begin
        n_err++;
        $display("FAIL %s: pend=%b mask=%b irq=%b expected pend=%b mask=%b irq=%b",
                 e.tag, pend_q, mask_q, irq_o, e.pend, e.mask, e.irq);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (mask_q !== 7'd0 || pend_q !== 7'd0 || irq_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1: pend=%b mask=%b irq=%b expected all zero", pend_q, mask_q, irq_o);
    end
    rst_n = 1'b1;

    step(6'b000001, 3'b000, 0, 0, 0, 0, "R3 done_a latches while masked");
    step(6'b000000, 3'b000, 1, 7'h7F, 0, 0, "R2 R6 mask write, reserved dropped, R9 irq rises");
    step(6'b000000, 3'b000, 0, 0, 0, 0, "R2 mask holds");
    step(6'b000000, 3'b000, 0, 0, 1, 7'h01, "R7 clear bit0, R9 irq falls");
    step(6'b001010, 3'b000, 0, 0, 0, 0, "R3 done_b and attach latch");
    step(6'b000000, 3'b000, 0, 0, 1, 7'h02, "R7 clear bit1 leaves bit5, R9 irq holds");
    step(6'b000000, 3'b000, 0, 0, 1, 7'h20, "R7 clear bit5, R9 irq falls");
    step(6'b000100, 3'b100, 0, 0, 0, 0, "R4 tick ignored with generator off");
    step(6'b000100, 3'b010, 0, 0, 0, 0, "R4 tick ignored with counter unloaded");
    step(6'b000100, 3'b110, 0, 0, 0, 0, "R4 tick latches when both set");
    step(6'b000000, 3'b000, 0, 0, 1, 7'h10, "R7 clear tick bit");
    step(6'b010000, 3'b001, 0, 0, 0, 0, "R5 detect ignored while suspended");
    step(6'b100000, 3'b001, 0, 0, 0, 0, "R5 resume latches while suspended");
    step(6'b000000, 3'b000, 0, 0, 1, 7'h40, "R7 clear bit6");
    step(6'b100000, 3'b000, 0, 0, 0, 0, "R5 resume ignored when not suspended");
    step(6'b010000, 3'b000, 0, 0, 0, 0, "R5 detect latches when not suspended");
    step(6'b000001, 3'b000, 0, 0, 1, 7'h41, "R8 event beats clear on bit0, bit6 cleared");
    step(6'b000000, 3'b000, 1, 7'h0C, 0, 0, "R6 reserved-only mask reads zero, R9 irq masked");
    step(6'b000000, 3'b000, 1, 7'h01, 0, 0, "R9 unmask pending bit raises irq");
    step(6'b000000, 3'b000, 0, 0, 1, 7'h7F, "R7 clear all, R6 reserved clear harmless");
    step(6'b111111, 3'b111, 1, 7'h7F, 1, 7'h7F, "R8 all events beat full clear");
    step(6'b000000, 3'b000, 0, 0, 1, 7'h7F, "R7 R9 full clear drops irq");
    step(6'b000000, 3'b000, 0, 0, 0, 0, "R2 idle holds");

    while (q_exp.size() > 0) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule